// File: doc/BRIEF.md
# Inter-Thread Storage Window Address Decoder

This block holds the configuration of a memory window through which threads reach a set of shared communication cells. A FIFO cell passes data between threads. A semaphore cell holds a count. Software programs two 64-bit map registers through a small configuration port. One register carries the window base address and an enable flag. The other carries a size mask and a cell-stride code. From these the block drives the window's base, size and enable.

Each storage access is checked against the window. When it hits, the block reports which cell it addresses and which access view the address encodes. The view is one of bypass, control, empty/full blocking, empty/full non-blocking, semaphore blocking and semaphore non-blocking. The cells are outside this block and consume the select outputs.

The cell stride is set at run time. An address that lands past the last cell still selects the last cell. A size change is applied only when the resulting size is a power of two. Any write that really changes a register raises a one-cycle reconfiguration pulse.

Top module: `itc_window_decoder`

## Requirements
- R1: After reset, map register 0 reads zero. Map register 1 reads 0xC00 with the cell count at bits [31:20]. The window size is 4096 and the window is disabled.
- R2: The register index is the configuration byte offset shifted right by 3. A write sets only the writable bits and leaves every other bit unchanged. The writable bits are [31:10] and [0] of register 0, and [16:10] and [2:0] of register 1. All other bits read back as zero, except the count field of R4.
- R3: A write to any index other than 0 or 1 changes neither register and raises no reconfiguration pulse. A read of such an index returns zero.
- R4: Bits [31:20] of register 1 always read the total cell count, which is NUM_FIFO + NUM_SEM. Writes cannot change this field.
- R5: The window base is register 0 bits [31:10] with the low 10 bits zero. The window enable is register 0 bit 0.
- R6: A register change recomputes the candidate size as 1024 plus register 1 bits [16:10] taken in place. The size becomes the candidate only if the candidate is a power of two. Otherwise the previous size stays.
- R7: The reconfiguration output is high for exactly the one cycle after a write that changed a register value. It stays low after a write that changed nothing.
- R8: For a hit, the selected cell is (address − base) shifted right by 7 plus the grain code in register 1 bits [2:0].
- R9: A computed cell index at or above the cell count selects the last cell, NUM_FIFO + NUM_SEM − 1.
- R10: For a hit, the view output is bits [6:3] of (address − base). Codes 0 to 5 are bypass, control, empty/full blocking, empty/full non-blocking, semaphore blocking and semaphore non-blocking.
- R11: An access makes a selection only when it is valid, the window is enabled, and base ≤ address < base + size. Otherwise the selection is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Configuration read data for cfg_addr (combinational) |
| acc_valid | input | 1 | Storage access present |
| acc_addr | input | 32 | Storage access address |
| win_base | output | 32 | Window base address |
| win_size | output | 32 | Window size in bytes |
| win_en | output | 1 | Window enable |
| reconfig | output | 1 | One-cycle pulse after a changing write |
| sel_valid | output | 1 | Access hits the enabled window |
| sel_cell | output | CW | Selected cell index |
| sel_view | output | 4 | Access view code |

## Verification
On every cycle, the assertions check the following:
- the window size stays a power of two;
- the size changes only together with the reconfiguration pulse;
- the pulse follows a write;
- a selection never appears with the window disabled;
- the selected cell is always below the cell count.

Other behaviour is shown only through the bench's scenarios, which compare against a reference model:
- the exact masked register contents;
- the rejection of a size that is not a power of two;
- dropped writes to unused offsets;
- the stride-dependent cell index and its folding onto the last cell;
- the window boundary limits.

// File: rtl/itc_window_decoder.sv
module itc_window_decoder #(
  parameter int NUM_FIFO = 16,
  parameter int NUM_SEM  = 16,
  parameter int CFG_AW   = 5,
  parameter int CW       = ((NUM_FIFO + NUM_SEM) > 1) ? $clog2(NUM_FIFO + NUM_SEM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  output logic [31:0]       win_base,
  output logic [31:0]       win_size,
  output logic              win_en,
  output logic              reconfig,
  output logic              sel_valid,
  output logic [CW-1:0]     sel_cell,
  output logic [3:0]        sel_view
);
  localparam int          NUM_CELLS = NUM_FIFO + NUM_SEM;
  localparam logic [63:0] MASK0     = 64'h0000_0000_FFFF_FC01;
  localparam logic [63:0] MASK1     = 64'h0000_0000_0001_FC07;
  localparam logic [63:0] RST1      = 64'h0000_0000_0000_0C00;
  localparam logic [31:0] RST_SIZE  = 32'd4096;

  logic [63:0] map0, map1, nxt0, nxt1;
  logic [31:0] size_q;
  logic        strobe_q;

  wire [CFG_AW-1:0] reg_idx = cfg_addr >> 3;

  always_comb begin
    nxt0 = map0;
    nxt1 = map1;
    if (cfg_we && reg_idx == CFG_AW'(0)) nxt0 = (cfg_wdata & MASK0) | (map0 & ~MASK0);
    if (cfg_we && reg_idx == CFG_AW'(1)) nxt1 = (cfg_wdata & MASK1) | (map1 & ~MASK1);
  end

  wire        changed = (nxt0 != map0) || (nxt1 != map1);
  wire [31:0] cand    = 32'd1024 + {15'd0, nxt1[16:10], 10'd0};
  wire        pow2    = (cand & (cand - 32'd1)) == 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map0     <= '0;
      map1     <= RST1;
      size_q   <= RST_SIZE;
      strobe_q <= 1'b0;
    end else begin
      map0     <= nxt0;
      map1     <= nxt1;
      strobe_q <= changed;
      if (changed && pow2) size_q <= cand;
    end
  end

  assign cfg_rdata = (reg_idx == CFG_AW'(0)) ? map0 :
                     (reg_idx == CFG_AW'(1)) ? (map1 | (64'(NUM_CELLS) << 20)) : 64'd0;

  assign win_base = {map0[31:10], 10'd0};
  assign win_en   = map0[0];
  assign win_size = size_q;
  assign reconfig = strobe_q;

  wire [32:0] limit  = {1'b0, win_base} + {1'b0, size_q};
  wire        in_win = win_en && (acc_addr >= win_base) && ({1'b0, acc_addr} < limit);
  wire [31:0] off    = acc_addr - win_base;
  wire [3:0]  shift  = 4'd7 + {1'b0, map1[2:0]};
  wire [31:0] raw    = off >> shift;

  assign sel_valid = acc_valid && in_win;
  assign sel_cell  = (raw >= 32'(NUM_CELLS)) ? CW'(NUM_CELLS - 1) : raw[CW-1:0];
  assign sel_view  = off[6:3];
endmodule

module itc_window_decoder_chk #(
  parameter int NUM_CELLS = 32,
  parameter int CW        = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          reconfig,
  input logic [31:0]   win_size,
  input logic          win_en,
  input logic          sel_valid,
  input logic [CW-1:0] sel_cell
);
  assert_size_pow2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_size) == 1);
  assert_size_moves_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(win_size) |-> reconfig);
  assert_pulse_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig |-> $past(cfg_we));
  assert_no_select_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> win_en);
  assert_cell_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (32'(sel_cell) < 32'(NUM_CELLS)));
endmodule

bind itc_window_decoder itc_window_decoder_chk #(
  .NUM_CELLS(NUM_FIFO + NUM_SEM), .CW(CW)
) chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .reconfig(reconfig),
  .win_size(win_size), .win_en(win_en), .sel_valid(sel_valid), .sel_cell(sel_cell)
);

// File: tb/itc_window_decoder_test.sv
module itc_window_decoder_test;
  localparam int NCELL = 32;
  localparam int CW = 5;

  logic clk = 0, rst_n = 0, cfg_we = 0, acc_valid = 0;
  logic [4:0] cfg_addr = 0;
  logic [63:0] cfg_wdata = 0, cfg_rdata;
  logic [31:0] acc_addr = 0, win_base, win_size;
  logic win_en, reconfig, sel_valid;
  logic [CW-1:0] sel_cell;
  logic [3:0] sel_view;

  itc_window_decoder uut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [63:0] m0, m1;
  logic [31:0] msize;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] rd_model(int idx);
    if (idx == 0) return m0;
    if (idx == 1) return m1 | (64'(NCELL) << 20);
    return 64'd0;
  endfunction

  task automatic readback(string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cfg_addr = 5'(i * 8 + ($urandom % 8));
      #1 chk(tag, cfg_rdata, rd_model(i));
    end
  endtask

  task automatic wr(logic [4:0] a, logic [63:0] d, string tag);
    logic [63:0] n0, n1;
    logic [31:0] cand;
    bit ch;
    n0 = m0; n1 = m1;
    if (a[4:3] == 2'd0) n0 = (d & 64'hFFFF_FC01) | (m0 & ~64'hFFFF_FC01);
    if (a[4:3] == 2'd1) n1 = (d & 64'h1_FC07) | (m1 & ~64'h1_FC07);
    ch = (n0 != m0) || (n1 != m1);
    cand = 32'd1024 + {15'd0, n1[16:10], 10'd0};
    if (ch && ((cand & (cand - 1)) == 0)) msize = cand;
    m0 = n0; m1 = n1;
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 0;
    chk({tag, " R7 pulse"}, {63'd0, reconfig}, {63'd0, ch});
    chk({tag, " R6 size"}, {32'd0, win_size}, {32'd0, msize});
    chk({tag, " R5 base"}, {32'd0, win_base}, {32'd0, m0[31:10], 10'd0});
    chk({tag, " R5 en"}, {63'd0, win_en}, {63'd0, m0[0]});
    @(posedge clk);
    #1 chk({tag, " R7 one cycle"}, {63'd0, reconfig}, 64'd0);
  endtask

  task automatic access(logic [31:0] a, string tag);
    logic [32:0] base, lim;
    logic [31:0] off, raw;
    bit hit;
    base = {1'b0, m0[31:10], 10'd0};
    lim = base + {1'b0, msize};
    hit = m0[0] && ({1'b0, a} >= base) && ({1'b0, a} < lim);
    off = a - base[31:0];
    raw = off >> (7 + m1[2:0]);
    if (raw >= NCELL) raw = NCELL - 1;
    @(negedge clk);
    acc_valid = 1; acc_addr = a;
    #1;
    chk({tag, " R11 hit"}, {63'd0, sel_valid}, {63'd0, hit});
    if (hit) begin
      chk({tag, " R8 cell"}, {59'd0, sel_cell}, {59'd0, raw[CW-1:0]});
      chk({tag, " R10 view"}, {60'd0, sel_view}, {60'd0, off[6:3]});
    end
    acc_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    m0 = 0; m1 = 64'hC00; msize = 4096;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R1 size", {32'd0, win_size}, 64'd4096);
    chk("R1 en", {63'd0, win_en}, 64'd0);
    chk("R1 pulse", {63'd0, reconfig}, 64'd0);
    readback("R1 R4 reset readback");

    wr(5'd0, 64'hFFFF_FFFF_1234_57FF, "R2 reg0 mask");
    readback("R2 readback");
    wr(5'd8, 64'hFFFF_FFFF_FFFF_FFFF, "R4 count write");
    readback("R4 readback");
    wr(5'd16, 64'hFFFF_FFFF_FFFF_FFFF, "R3 idx2");
    wr(5'd31, 64'h0, "R3 idx3");
    readback("R3 readback");
    wr(5'd8, 64'h0000_0000_0000_1C00, "R6 pow2 8k");
    wr(5'd8, 64'h0000_0000_0000_0800, "R6 non pow2");
    wr(5'd8, 64'h0000_0000_0000_0800, "R7 unchanged");
    wr(5'd0, 64'h0001_0001, "R5 enable");
    access(32'h0001_1F80, "R9 clamp");
    chk("R9 last cell", {59'd0, sel_cell}, 64'(NCELL - 1));
    access(32'h0001_0000 + 32'd8192, "R11 top edge");
    access(32'h0000_FFF8, "R11 below base");
    access(32'h0001_0028, "R10 view5");
    wr(5'd0, 64'h0001_0000, "R11 disable");
    access(32'h0001_0040, "R11 disabled");

    for (int i = 0; i < 400; i++) begin
      if ($urandom % 4 == 0) begin
        logic [63:0] d;
        d = {$urandom, $urandom};
        if ($urandom % 2 == 0) begin
          case ($urandom % 6)
            0: d[16:10] = 7'd0; 1: d[16:10] = 7'd1; 2: d[16:10] = 7'd3;
            3: d[16:10] = 7'd7; 4: d[16:10] = 7'd127; default: d[16:10] = 7'd5;
          endcase
          d[31:28] = 4'd0;
          d[0] = ($urandom % 4 != 0);
        end
        wr(5'($urandom), d, "rand R2");
      end else begin
        logic [31:0] a;
        a = {m0[31:10], 10'd0} + ($urandom % (msize + 2048)) - 32'd512;
        access(a, "rand");
      end
    end
    readback("R2 final readback");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule